// File: doc/BRIEF.md
# Nonvolatile Array Operation Sequencer

This block holds the 16-bit control and status word for an on-chip nonvolatile array. It launches, supervises and reports one program or erase operation at a time. Software writes an operation code, an enable bit and a start bit in a single register write. If the request is legal, the block latches an aligned target address and raises a one-cycle start pulse toward the array. It then stays busy until the array returns a done pulse or an internal cycle budget runs out.

Illegal start attempts and expired budgets raise a sticky error flag. A software-set standby bit turns an accepted idle request into a low-power hint for the array regulator. When that hint drops, the array is reported not ready for a fixed wake-up delay. The idle request itself is refused while an operation is running. A warm reset and a power-on reset are separate inputs, and the error and standby bits survive the warm reset.

Top module: `flash_seq_top`

## Requirements
- R1: The register reads as {start[15], enable[14], error[13], standby[12], zeros[11:4], opcode[3:0]}. Bits 11:4 always read 0, whatever was written to them.
- R2: A write with bit 15 = 1, while not busy, with bit 14 = 1 and opcode 4'b0011 (page erase) or 4'b0001 (double-word program), makes `busy` high in the next cycle. In that same first busy cycle `arrStart` pulses for exactly one cycle, with `arrErase` = 1 for erase and 0 for program.
- R3: A start write with bit 14 = 0, or with any opcode other than 4'b0011 and 4'b0001, sets the error bit. It starts nothing: `busy` and bit 15 stay 0 and no `arrStart` pulse appears. The enable and opcode fields take the written values.
- R4: Bit 15 can only be set by software. While busy, writes of 0 to bit 15 have no effect, and writes to the enable and opcode fields are ignored.
- R5: A high `arrDone` during a busy cycle clears bit 15 and `busy` at the next edge and leaves the error bit unchanged. `arrDone` outside an operation has no effect.
- R6: If no done arrives, the operation is aborted after exactly TIMEOUT busy cycles. Bit 15 clears and the error bit sets.
- R7: A register write with bit 13 = 0 clears the error bit, unless the same write raises it. Writing 1 to bit 13 never sets it.
- R8: `arrAddr` holds the target address latched at launch. For erase, the low PAGE_BITS bits are cleared. For program, bit 0 is cleared.
- R9: `sleepAck` follows `sleepReq` only while not busy, and is 0 during any operation.
- R10: `arrStandby` is `sleepAck` AND the standby bit. After `arrStandby` falls, `arrReady` stays 0 for WAKE further clock edges and rises after the next one. With the standby bit at 0, `arrReady` stays 1.
- R11: A warm reset (`rstN` low) clears start, enable and opcode and keeps the error and standby bits. A power-on reset (`porN` low) clears everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| rstN | input | 1 | Warm reset, active low, asynchronous |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read value |
| tgtAddr | input | AW | Target word address, latched at launch |
| busy | output | 1 | Operation in progress (mirror of bit 15) |
| arrStart | output | 1 | One-cycle start pulse to the array |
| arrErase | output | 1 | 1 = page erase, 0 = double-word program |
| arrAddr | output | AW | Aligned address of the running operation |
| arrDone | input | 1 | Completion pulse from the array |
| sleepReq | input | 1 | Request to enter the idle power state |
| sleepAck | output | 1 | Idle request accepted |
| arrStandby | output | 1 | Low-power hint to the array regulator |
| arrReady | output | 1 | Array usable (low during standby and wake delay) |

## Verification
The hardest state to reach is the timeout abort. The array stub must deliberately withhold its done pulse while the bench counts busy cycles, so that it can confirm the abort lands on exactly the TIMEOUT-th cycle. The warm-reset retention case is also awkward to set up. Both the error and standby bits must be raised together first, which the bench does with one rejected start write that also sets the standby bit, before pulsing `rstN`. The wake delay is measured by dropping `sleepReq` while standby is armed and counting edges until `arrReady` returns.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam logic [3:0] OP_PAGE_ERASE = 4'b0011;
  localparam logic [3:0] OP_DWORD_PROG = 4'b0001;

  typedef struct packed {
    logic launch;  // legal start accepted
    logic reject;  // illegal start attempt
    logic finish;  // array reported done
    logic abort;   // budget expired
  } seqStrobes_t;
endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int TIMEOUT = 64,
  parameter int WAKE    = 8
) (
  input  logic        clk,
  input  logic        sysRstN,
  input  logic        regWrEn,
  input  logic        wrStart,
  input  logic        wrEnable,
  input  logic [3:0]  wrOp,
  input  logic        busy,
  input  logic        standbyBit,
  input  logic        arrDone,
  input  logic        sleepReq,
  output seqStrobes_t strobes,
  output logic        sleepAck,
  output logic        arrStandby,
  output logic        arrReady
);
  localparam int TW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam int WW = $clog2(WAKE + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TIMEOUT - 1);

  logic [TW-1:0] tmoCnt;
  logic [WW-1:0] wakeCnt;
  logic          standbyQ;
  logic          startReq, legalReq, budgetOut;

  always_comb begin
    startReq  = regWrEn && wrStart && !busy;
    legalReq  = wrEnable && (wrOp == OP_PAGE_ERASE || wrOp == OP_DWORD_PROG);
    budgetOut = (tmoCnt == TMO_LAST);
    strobes.launch = startReq && legalReq;
    strobes.reject = startReq && !legalReq;
    strobes.finish = busy && arrDone;
    strobes.abort  = busy && !arrDone && budgetOut;
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) tmoCnt <= '0;
    else if (strobes.launch) tmoCnt <= '0;
    else if (busy && !arrDone && !budgetOut) tmoCnt <= tmoCnt + 1'b1;
  end

  assign sleepAck   = sleepReq && !busy;
  assign arrStandby = sleepAck && standbyBit;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      standbyQ <= 1'b0;
      wakeCnt  <= '0;
    end else begin
      standbyQ <= arrStandby;
      if (standbyQ && !arrStandby) wakeCnt <= WW'(WAKE);
      else if (wakeCnt != '0)      wakeCnt <= wakeCnt - 1'b1;
    end
  end

  assign arrReady = !arrStandby && !standbyQ && (wakeCnt == '0);
endmodule

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int PAGE_BITS = 6
) (
  input  logic          clk,
  input  logic          sysRstN,
  input  logic          porN,
  input  logic          regWrEn,
  input  logic          wrEnable,
  input  logic          wrErr,
  input  logic          wrStandby,
  input  logic [3:0]    wrOp,
  input  logic [AW-1:0] tgtAddr,
  input  seqStrobes_t   strobes,
  output logic [15:0]   regRdData,
  output logic          busy,
  output logic          standbyBit,
  output logic          arrStart,
  output logic          arrErase,
  output logic [AW-1:0] arrAddr
);
  localparam logic [AW-1:0] PAGE_MASK = ~AW'((1 << PAGE_BITS) - 1);
  localparam logic [AW-1:0] DW_MASK   = ~AW'(1);

  logic       startQ, enableQ, errQ, standbyQ;
  logic [3:0] opQ;
  logic       isErase;

  assign isErase = (wrOp == OP_PAGE_ERASE);

  // Warm-resettable state
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      startQ   <= 1'b0;
      enableQ  <= 1'b0;
      opQ      <= '0;
      arrStart <= 1'b0;
      arrErase <= 1'b0;
      arrAddr  <= '0;
    end else begin
      arrStart <= strobes.launch;
      if (strobes.launch)                        startQ <= 1'b1;
      else if (strobes.finish || strobes.abort)  startQ <= 1'b0;
      if (regWrEn && !startQ) begin
        enableQ <= wrEnable;
        opQ     <= wrOp;
      end
      if (strobes.launch) begin
        arrErase <= isErase;
        arrAddr  <= tgtAddr & (isErase ? PAGE_MASK : DW_MASK);
      end
    end
  end

  // Power-on-only state
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      errQ     <= 1'b0;
      standbyQ <= 1'b0;
    end else begin
      if (strobes.reject || strobes.abort) errQ <= 1'b1;
      else if (regWrEn && !wrErr)          errQ <= 1'b0;
      if (regWrEn) standbyQ <= wrStandby;
    end
  end

  assign busy       = startQ;
  assign standbyBit = standbyQ;
  assign regRdData  = {startQ, enableQ, errQ, standbyQ, 8'h00, opQ};
endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
  import flash_seq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int PAGE_BITS = 6,
  parameter int TIMEOUT   = 64,
  parameter int WAKE      = 8
) (
  input  logic          clk,
  input  logic          porN,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [15:0]   regWrData,
  output logic [15:0]   regRdData,
  input  logic [AW-1:0] tgtAddr,
  output logic          busy,
  output logic          arrStart,
  output logic          arrErase,
  output logic [AW-1:0] arrAddr,
  input  logic          arrDone,
  input  logic          sleepReq,
  output logic          sleepAck,
  output logic          arrStandby,
  output logic          arrReady
);
  seqStrobes_t strobes;
  logic        sysRstN, standbyBit;
  logic        unusedBits;

  assign sysRstN    = rstN && porN;
  assign unusedBits = ^regWrData[11:4];

  flash_seq_ctrl #(.TIMEOUT(TIMEOUT), .WAKE(WAKE)) ctrl_i (
    .clk(clk), .sysRstN(sysRstN), .regWrEn(regWrEn),
    .wrStart(regWrData[15]), .wrEnable(regWrData[14]), .wrOp(regWrData[3:0]),
    .busy(busy), .standbyBit(standbyBit), .arrDone(arrDone), .sleepReq(sleepReq),
    .strobes(strobes), .sleepAck(sleepAck), .arrStandby(arrStandby), .arrReady(arrReady)
  );

  flash_seq_dp #(.AW(AW), .PAGE_BITS(PAGE_BITS)) dp_i (
    .clk(clk), .sysRstN(sysRstN), .porN(porN), .regWrEn(regWrEn),
    .wrEnable(regWrData[14]), .wrErr(regWrData[13]), .wrStandby(regWrData[12]),
    .wrOp(regWrData[3:0]), .tgtAddr(tgtAddr), .strobes(strobes),
    .regRdData(regRdData), .busy(busy), .standbyBit(standbyBit),
    .arrStart(arrStart), .arrErase(arrErase), .arrAddr(arrAddr)
  );
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int AW      = 16,
  parameter int TIMEOUT = 64
) (
  input logic          clk,
  input logic          porN,
  input logic          rstN,
  input logic          regWrEn,
  input logic [15:0]   regWrData,
  input logic [15:0]   regRdData,
  input logic          busy,
  input logic          arrStart,
  input logic [AW-1:0] arrAddr,
  input logic          arrDone,
  input logic          sleepAck,
  input logic          arrStandby,
  input logic          arrReady
);
  logic [31:0] busyRun;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                busyRun <= '0;
    else if (!rstN || !busy)  busyRun <= '0;
    else if (!arrDone)        busyRun <= busyRun + 1;
  end

  // R2: the start pulse only appears when an operation begins
  assert_start_in_busy_R2: assert property (@(posedge clk) disable iff (!rstN || !porN)
    $rose(busy) |-> arrStart);
  assert_start_only_busy_R2: assert property (@(posedge clk) disable iff (!rstN || !porN)
    arrStart |-> busy);
  // R3: a start without enable raises the error flag and starts nothing
  assert_illegal_start_R3: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (!busy && regWrEn && regWrData[15] && !regWrData[14]) |=> (!busy && regRdData[13]));
  // R8: the address does not move during an operation
  assert_addr_held_R8: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (busy && $past(busy)) |-> $stable(arrAddr));
  // R6: no operation outlives its budget
  assert_budget_R6: assert property (@(posedge clk) disable iff (!rstN || !porN)
    busyRun <= TIMEOUT);
  // R9: idle requests are refused during an operation
  assert_no_sleep_busy_R9: assert property (@(posedge clk) disable iff (!rstN || !porN)
    busy |-> !sleepAck);
  // R10: the array is never ready while in standby
  assert_standby_not_ready_R10: assert property (@(posedge clk) disable iff (!rstN || !porN)
    arrStandby |-> !arrReady);
endmodule

bind flash_seq_top flash_seq_chk #(.AW(AW), .TIMEOUT(TIMEOUT)) chk_i (
  .clk(clk), .porN(porN), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
  .regRdData(regRdData), .busy(busy), .arrStart(arrStart), .arrAddr(arrAddr),
  .arrDone(arrDone), .sleepAck(sleepAck), .arrStandby(arrStandby), .arrReady(arrReady)
);

// File: tb/flash_seq_top_tb_top.sv
module flash_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, PAGE_BITS = 6, TIMEOUT = 20, WAKE = 5;

  logic          clk = 1'b0;
  logic          porN = 1'b0, rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [15:0]   regWrData = '0;
  logic [15:0]   regRdData;
  logic [AW-1:0] tgtAddr = '0;
  logic          busy, arrStart, arrErase, arrDone = 1'b0;
  logic [AW-1:0] arrAddr;
  logic          sleepReq = 1'b0, sleepAck, arrStandby, arrReady;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { string req; int expVal; } expItem_t;
  expItem_t scoreQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_seq_top #(.AW(AW), .PAGE_BITS(PAGE_BITS), .TIMEOUT(TIMEOUT), .WAKE(WAKE)) dut_i (
    .clk(clk), .porN(porN), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .tgtAddr(tgtAddr), .busy(busy), .arrStart(arrStart),
    .arrErase(arrErase), .arrAddr(arrAddr), .arrDone(arrDone), .sleepReq(sleepReq),
    .sleepAck(sleepAck), .arrStandby(arrStandby), .arrReady(arrReady)
  );

  // driver side: push an expectation
  task automatic expect_item(input string req, input int v);
    expItem_t it;
    it.req = req; it.expVal = v;
    scoreQ.push_back(it);
  endtask

  // monitor side: pop and compare against what the design produced
  task automatic observe(input int act);
    expItem_t it;
    checks++;
    if (scoreQ.size() == 0) begin
      errors++;
      $display("FAIL scoreboard empty act=%0h", act);
    end else begin
      it = scoreQ.pop_front();
      if (act != it.expVal) begin
        errors++;
        $display("FAIL %s act=%0h exp=%0h", it.req, act, it.expVal);
      end
    end
  endtask

  task automatic chk(input string req, input int act, input int v);
    expect_item(req, v);
    observe(act);
  endtask

  task automatic regWrite(input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulseDone();
    arrDone = 1'b1;
    @(negedge clk);
    arrDone = 1'b0;
  endtask

  int startSeen = 0;
  always @(posedge clk) if (arrStart) startSeen++;

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int s0;
    repeat (3) @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    @(negedge clk);
    // R11 / R1 reset state
    chk("R11 reset reg", regRdData, 16'h0000);
    chk("R11 reset busy", busy, 0);
    chk("R10 reset ready", arrReady, 1);

    // R1: bits 11:4 read zero
    regWrite(16'h4FF3);
    chk("R1 unimplemented bits", regRdData, 16'h4003);

    // R3: start with enable 0
    s0 = startSeen;
    regWrite(16'h8003);
    chk("R3 no enable reg", regRdData, 16'h2003);
    chk("R3 no enable pulse", startSeen - s0, 0);
    // R7: writing 1 to error keeps it, writing 0 clears
    regWrite(16'h2000);
    chk("R7 write one keeps", regRdData[13], 1);
    regWrite(16'h0000);
    chk("R7 clear error", regRdData, 16'h0000);

    // R3: reserved opcode
    regWrite(16'hC002);
    chk("R3 reserved op reg", regRdData, 16'h6002);
    chk("R3 reserved op busy", busy, 0);

    // R5: stray done outside an operation
    pulseDone();
    chk("R5 stray done", regRdData, 16'h6002);

    // R2/R8: page erase
    tgtAddr = 16'h12F7;
    s0 = startSeen;
    regWrite(16'hC003);
    chk("R2 erase busy", busy, 1);
    chk("R2 erase pulse", arrStart, 1);
    chk("R2 erase type", arrErase, 1);
    chk("R8 erase addr", arrAddr, 16'h12C0);
    chk("R7 legal start clears error", regRdData, 16'hC003);
    @(negedge clk);
    chk("R2 pulse single", startSeen - s0, 1);
    // R4: writes while busy ignored
    regWrite(16'h0001);
    chk("R4 busy write ignored", regRdData & 16'hC00F, 16'hC003);
    // R9
    sleepReq = 1'b1; #1;
    chk("R9 no ack while busy", sleepAck, 0);
    sleepReq = 1'b0;
    @(negedge clk);
    pulseDone();
    chk("R5 done clears start", regRdData, 16'h4003);

    // R2/R8: double-word program
    tgtAddr = 16'h0A35;
    regWrite(16'hC001);
    chk("R2 program type", arrErase, 0);
    chk("R8 program addr", arrAddr, 16'h0A34);
    pulseDone();
    chk("R5 program done", regRdData, 16'h4001);

    // R6: timeout
    regWrite(16'hC001);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk("R6 busy cycles", n, TIMEOUT);
    chk("R6 abort reg", regRdData, 16'h6001);

    // R11: warm reset retains error and standby
    regWrite(16'h9000);
    chk("R11 setup", regRdData, 16'h3000);
    regWrite(16'h1003);
    regWrite(16'h5003);
    regWrite(16'h9003);
    chk("R11 setup2", regRdData, 16'h3003);
    rstN = 1'b0; @(negedge clk); rstN = 1'b1; @(negedge clk);
    chk("R11 warm reset", regRdData, 16'h3000);
    porN = 1'b0; @(negedge clk); porN = 1'b1; @(negedge clk);
    chk("R11 power-on reset", regRdData, 16'h0000);

    // R10: standby and wake delay
    regWrite(16'h1000);
    sleepReq = 1'b1; #1;
    chk("R10 ack", sleepAck, 1);
    chk("R10 standby", arrStandby, 1);
    chk("R10 not ready", arrReady, 0);
    @(negedge clk);
    sleepReq = 1'b0;
    for (int i = 0; i < WAKE; i++) begin
      @(negedge clk);
      chk("R10 wake low", arrReady, 0);
    end
    @(negedge clk);
    chk("R10 wake done", arrReady, 1);

    // R10: standby bit clear -> no hint, no delay
    regWrite(16'h0000);
    sleepReq = 1'b1; #1;
    chk("R10 ack no sby", sleepAck, 1);
    chk("R10 no hint", arrStandby, 0);
    @(negedge clk);
    sleepReq = 1'b0;
    @(negedge clk);
    chk("R10 ready kept", arrReady, 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule